// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one 32-bit integer by another over several clock cycles using the restoring method, one quotient bit per cycle. A single wide accumulator first holds the dividend. On every step it shifts left, the divisor is trial-subtracted from its upper part, and the outcome bit enters at the bottom. When all steps are done, the low part holds the quotient and the upper part, shifted back one place, holds the remainder.

A one-cycle start pulse loads both operands and a mode bit. In unsigned mode the operands are taken as plain binary numbers. In signed mode the block divides the magnitudes of the two's-complement operands. It then sets the quotient's sign from the two operand signs and gives the remainder the dividend's sign. There is no divide-by-zero detection: a zero divisor gives an unspecified result.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted and directly after it, busy and done are 0 and quotient and remainder are 0.
- R2: A start pulse while the block is idle makes busy rise at the next clock edge. Busy then stays high for exactly WIDTH+1 cycles (33 by default): WIDTH quotient steps plus one sign fix-up cycle.
- R3: done is high for exactly one cycle, the first cycle after busy falls. From that cycle on, quotient and remainder are valid and hold their values until the next completion.
- R4: In unsigned mode (signed_mode = 0 at start) with a nonzero divisor, quotient = floor(dividend / divisor) and remainder = dividend - quotient * divisor.
- R5: Unsigned divisors with the most significant bit set give correct results. The trial subtraction is one bit wider than the operands, so its borrow is not confused with bit 31 of the difference.
- R6: In signed mode (signed_mode = 1 at start) the quotient is the magnitude quotient, negated when the sign bits of dividend and divisor differ, so it rounds toward zero.
- R7: In signed mode the remainder has the dividend's sign (or is zero) and a magnitude below the divisor's. Example: -7 / 2 gives quotient -3, remainder -1.
- R8: A start pulse while busy is high is ignored. The running operation completes with its own operands, and no extra done pulse follows.
- R9: When the dividend's magnitude is below the divisor's, the quotient is 0 and the remainder equals the dividend, including a zero dividend.
- R10: dividend, divisor and signed_mode are sampled only at an accepted start. Changing them while busy does not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | WIDTH | Number to be divided |
| divisor | input | WIDTH | Number to divide by |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse, results valid |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |

## Verification
Most internal faults in this block show up only once done pulses. A wrong restore decision or a misplaced shift bit corrupts one quotient bit and the remainder, and a wrong step count shifts the whole result; both are visible exactly 34 cycles after start. A fault in the step counter or the state sequence also shows as a busy window of the wrong length, caught the cycle busy falls. Sign fix-up faults affect only signed operands with mixed signs, so the stimulus covers every sign pairing. Divisors with the top bit set are included to expose a borrow taken from the wrong bit.

// File: rtl/seq_divider.sv
`timescale 1ns/1ps
module seq_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam int AW = 2 * WIDTH + 1;

  typedef enum logic [1:0] {IDLE, STEP, FIXUP} state_t;

  state_t           state;
  logic [AW-1:0]    acc;
  logic [WIDTH-1:0] dvs;
  logic [CW-1:0]    step;
  logic             neg_q, neg_r;

  wire              accept = start && (state == IDLE);
  wire              n_neg  = signed_mode && dividend[WIDTH-1];
  wire              d_neg  = signed_mode && divisor[WIDTH-1];
  wire [WIDTH-1:0]  n_mag  = n_neg ? -dividend : dividend;
  wire [WIDTH-1:0]  d_mag  = d_neg ? -divisor  : divisor;

  wire [WIDTH:0]    upper  = acc[AW-1:WIDTH];
  wire [WIDTH-1:0]  lower  = acc[WIDTH-1:0];
  wire [WIDTH+1:0]  trial  = {1'b0, upper} - {2'b00, dvs};
  wire              fits   = ~trial[WIDTH+1];
  wire [WIDTH:0]    kept   = fits ? trial[WIDTH:0] : upper;
  wire [WIDTH-1:0]  rem_u  = acc[AW-1:WIDTH+1];

  assign busy = (state != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      acc       <= '0;
      dvs       <= '0;
      step      <= '0;
      neg_q     <= 1'b0;
      neg_r     <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (accept) begin
          acc   <= {{WIDTH{1'b0}}, n_mag, 1'b0};
          dvs   <= d_mag;
          neg_q <= n_neg ^ d_neg;
          neg_r <= n_neg;
          step  <= '0;
          state <= STEP;
        end
        STEP: begin
          acc  <= {kept[WIDTH-1:0], lower, fits};
          step <= step + 1'b1;
          if (step == CW'(WIDTH - 1)) state <= FIXUP;
        end
        FIXUP: begin
          quotient  <= neg_q ? -lower : lower;
          remainder <= neg_r ? -rem_u : rem_u;
          done      <= 1'b1;
          state     <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_divider_chk.sv
`timescale 1ns/1ps
module seq_divider_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             signed_mode,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);
  localparam int LW = $clog2(WIDTH + 3) + 1;

  logic [LW-1:0]    busy_len;
  logic [WIDTH-1:0] cap_n, cap_d;
  logic             cap_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= '0;
      cap_n    <= '0;
      cap_d    <= '0;
      cap_s    <= 1'b0;
    end else begin
      busy_len <= busy ? busy_len + 1'b1 : '0;
      if (start && !busy) begin
        cap_n <= dividend;
        cap_d <= divisor;
        cap_s <= signed_mode;
      end
    end
  end

  wire [2*WIDTH-1:0] rebuilt = {{WIDTH{1'b0}}, quotient} * {{WIDTH{1'b0}}, cap_d}
                             + {{WIDTH{1'b0}}, remainder};

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == LW'(WIDTH + 1));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));

  assert_unsigned_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_s && cap_d != '0) |->
      (rebuilt == {{WIDTH{1'b0}}, cap_n} && remainder < cap_d));

  assert_rem_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_s && remainder != '0) |-> remainder[WIDTH-1] == cap_n[WIDTH-1]);
endmodule

bind seq_divider seq_divider_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_seq_divider.sv
`timescale 1ns/1ps
module sim_seq_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  int busy_cycles = 0;
  bit finished = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_exp = '0;

  seq_divider #(.WIDTH(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  always #10 clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cycles++;
      if (done) begin
        logic [63:0] e;
        string t;
        checks++;
        if (busy_cycles != 33) begin
          errors++;
          $display("FAIL R2 busy length actual=%0d expected=33", busy_cycles);
        end
        busy_cycles = 0;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected done actual q=%h r=%h expected=none", quotient, remainder);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({quotient, remainder} !== e) begin
            errors++;
            $display("FAIL %s actual q=%h r=%h expected q=%h r=%h",
                     t, quotient, remainder, e[63:32], e[31:0]);
          end
        end
      end
    end
  end

  task automatic run_op(input logic [31:0] n, input logic [31:0] d, input logic s,
                        input string tag, input bit poke);
    logic [31:0] q, r;
    if (s) begin
      q = $signed(n) / $signed(d);
      r = $signed(n) % $signed(d);
    end else begin
      q = n / d;
      r = n % d;
    end
    last_exp = {q, r};
    exp_q.push_back({q, r});
    tag_q.push_back(tag);
    @(negedge clk);
    dividend = n; divisor = d; signed_mode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      dividend = ~n; divisor = d ^ 32'h5; signed_mode = ~s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      dividend = 32'h1234; divisor = 32'h3;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || quotient !== '0 || remainder !== '0) begin
      errors++;
      $display("FAIL R1 reset state actual b=%b d=%b q=%h r=%h expected all zero",
               busy, done, quotient, remainder);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset actual b=%b d=%b expected 0 0", busy, done);
    end

    @(negedge clk);
    dividend = 32'd100; divisor = 32'd7; signed_mode = 1'b0; start = 1'b1;
    exp_q.push_back({32'd14, 32'd2}); tag_q.push_back("R4 100/7");
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (busy !== 1'b1) begin
      errors++;
      $display("FAIL R2 busy after start actual=%b expected=1", busy);
    end
    while (!done) @(negedge clk);
    @(negedge clk);

    run_op(32'hFFFFFFFF, 32'd1, 1'b0, "R4 max/1", 0);
    run_op(32'd12345678, 32'd1000, 1'b0, "R4 12345678/1000", 0);
    run_op(32'hDEADBEEF, 32'h00012345, 1'b0, "R4 mixed bits", 0);
    run_op(32'hFFFFFFFF, 32'h80000000, 1'b0, "R5 msb divisor", 0);
    run_op(32'hF0000000, 32'h80000001, 1'b0, "R5 msb divisor rem", 0);
    run_op(32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0, "R5 near max", 0);
    run_op(32'd3, 32'd10, 1'b0, "R9 small dividend", 0);
    run_op(32'd0, 32'd5, 1'b0, "R9 zero dividend", 0);
    run_op(32'h80000000, 32'hFFFFFFFF, 1'b0, "R9 unsigned below", 0);
    run_op(-32'sd7, 32'sd2, 1'b1, "R7 -7/2", 0);
    run_op(32'sd7, -32'sd2, 1'b1, "R6 7/-2", 0);
    run_op(-32'sd7, -32'sd2, 1'b1, "R6 -7/-2", 0);
    run_op(-32'sd100, 32'sd7, 1'b1, "R7 -100/7", 0);
    run_op(32'sd100, -32'sd3, 1'b1, "R6 100/-3", 0);
    run_op(-32'sd5, 32'sd9, 1'b1, "R9 signed below", 0);
    run_op(32'h80000000, 32'sd3, 1'b1, "R6 most negative", 0);

    run_op(32'd1000000, 32'd37, 1'b0, "R8 start while busy", 1);
    run_op(-32'sd1000, 32'sd33, 1'b1, "R10 mode change while busy", 1);

    repeat (10) @(negedge clk);
    checks++;
    if ({quotient, remainder} !== last_exp || done !== 1'b0) begin
      errors++;
      $display("FAIL R3 hold actual q=%h r=%h expected q=%h r=%h",
               quotient, remainder, last_exp[63:32], last_exp[31:0]);
    end

    repeat (40) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 missing done actual pending=%0d expected=0", exp_q.size());
    end
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end
endmodule